// File: doc/BRIEF.md
# Serial Gamepad Auto-Poll Sequencer

This block reads two serial gamepad ports once per video frame without any processor help. When the auto-poll enable is set at the start of vertical blank, the sequencer waits on that scanline for a fixed horizontal position. It then raises a shared latch line once and clocks both ports side by side for sixteen bit periods. Each port supplies two data lines, so every run fills four 16-bit result registers. The first bit shifted out of a pad ends up as the most significant bit.

All timing counts master-clock enables (`tick`), so the block runs from a fast system clock with a qualifying enable. A run is 16 bit periods of 264 ticks each, 4224 ticks in total, and a busy flag is high for exactly that span. Outside a run, a processor may drive the latch and request single read strobes through plain control pins. While a run is in progress those requests are dropped. Results are level registers that change only when a run completes. There is no data stream at the edge, so no valid/ready pair and no back-pressure. Every pin is a plain control, status or data level.

Top module: `pad_autopoll`

## Requirements
- R1: After reset, all four result registers read 0, and `busy`, `pad_latch`, `pad1_clk` and `pad2_clk` are 0.
- R2: A run starts only if `autoread_en` is 1 when `vblank_start` pulses. The block then arms and waits. `busy` rises on the first clock edge at which `tick` is 1 and `hcount` equals the start position (default 64, inside the 33..95 window). With `autoread_en` at 0, or with no vertical-blank pulse, no run starts.
- R3: `busy` stays 1 for exactly 4224 ticks: 16 periods of 264 ticks. It falls on the edge of the last tick.
- R4: During a run, `pad_latch` goes high once, only in the first period, at period positions 4 to 27 (24 ticks), and is low for every later tick.
- R5: Each run gives exactly 16 rising edges on `pad1_clk` and on `pad2_clk`. The two strobes are equal on every cycle of the run and are never high while `pad_latch` is high.
- R6: Lane mapping: `port1_d[0]` fills `res1`, `port2_d[0]` fills `res2`, `port1_d[1]` fills `res3`, `port2_d[1]` fills `res4`.
- R7: Bit order is MSB-first. The line value sampled in period 0 lands in bit 15 and the value sampled in period 15 lands in bit 0. Each sample is taken at period position 96, before that period's strobe (positions 100 to 131).
- R8: Data lines are captured inverted: a line held at 0 stores a 1.
- R9: The result registers keep their previous values for the whole run. They take the new values on the same edge on which `busy` falls.
- R10: While `busy` is 1, `man_latch_wr` and `man_rd1`/`man_rd2` have no effect. They add no latch cycles and no strobes, and the latch is still low after the run.
- R11: When `busy` is 0, `man_latch_wr` loads `man_latch_val` onto `pad_latch` from the next clock edge. A `man_rdN` pulse gives a one-cycle high on `padN_clk` in the next cycle, on that port only.
- R12: A run leaves `pad_latch` low and does not reload the pads. A manual strobe after the run shifts out the next bit past the sixteenth.
- R13: Timing advances only on cycles with `tick` at 1. With `tick` high every other cycle, a run lasts 8448 clock cycles and the latch is high for 48 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Master-clock enable; all run timing counts these |
| autoread_en | input | 1 | Auto-poll enable, sampled at `vblank_start` |
| vblank_start | input | 1 | One-cycle pulse at the first vertical-blank scanline |
| hcount | input | 9 | Horizontal position counter |
| man_latch_wr | input | 1 | Manual latch write strobe |
| man_latch_val | input | 1 | Value for manual latch write |
| man_rd1 | input | 1 | Manual read-strobe request, port 1 |
| man_rd2 | input | 1 | Manual read-strobe request, port 2 |
| port1_d | input | 2 | Port 1 raw data lines (bit 0 = line 1) |
| port2_d | input | 2 | Port 2 raw data lines (bit 0 = line 1) |
| pad_latch | output | 1 | Shared latch to both ports |
| pad1_clk | output | 1 | Read strobe to port 1 |
| pad2_clk | output | 1 | Read strobe to port 2 |
| res1 | output | 16 | Port 1 line 1 result |
| res2 | output | 16 | Port 2 line 1 result |
| res3 | output | 16 | Port 1 line 2 result |
| res4 | output | 16 | Port 2 line 2 result |
| busy | output | 1 | Auto-poll in progress |

## Verification
The hardest case to reach from the ports is a manual latch write or strobe request landing in the middle of a run. It can only be seen indirectly, through the pad's shift position and the final results. The stimulus sends such requests about a thousand cycles into a run. A bench pad model with a 24-bit shift chain shows any stray strobe or relatch as a changed result or an extra edge count. The same model exposes the bits past the sixteenth, so a manual strobe after the run can be shown to continue the shift rather than restart it. A second hard case is the gated-tick run, which the bench reaches by toggling `tick` every cycle.

// File: rtl/pad_autopoll_pkg.sv
package pad_autopoll_pkg;
  localparam int NUM_PORTS = 2;
  localparam int LINES_PER_PORT = 2;
  localparam int NUM_LANES = NUM_PORTS * LINES_PER_PORT;

  // lane k reads port (k mod ports), line (k div ports)
  function automatic int lane_port(input int k);
    return k % NUM_PORTS;
  endfunction

  function automatic int lane_line(input int k);
    return k / NUM_PORTS;
  endfunction
endpackage

// File: rtl/pad_autopoll_seq.sv
module pad_autopoll_seq #(
  parameter int BITS       = 16,
  parameter int PERIOD     = 264,
  parameter int H_W        = 9,
  parameter int START_H    = 64,
  parameter int LATCH_BEG  = 4,
  parameter int LATCH_END  = 28,
  parameter int SAMPLE_AT  = 96,
  parameter int STROBE_BEG = 100,
  parameter int STROBE_END = 132
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           enable,
  input  logic           vblank_start,
  input  logic [H_W-1:0] hcount,
  output logic           busy,
  output logic           start_now,
  output logic           run_done,
  output logic           sample_now,
  output logic           auto_latch,
  output logic           auto_strobe
);
  localparam int PH_W = $clog2(PERIOD);
  localparam int B_W  = $clog2(BITS);

  logic            armed;
  logic [PH_W-1:0] phase;
  logic [B_W-1:0]  bidx;
  logic            at_start_h, last_phase, last_bit;

  assign at_start_h = (hcount == H_W'(START_H));
  assign last_phase = (phase == PH_W'(PERIOD - 1));
  assign last_bit   = (bidx == B_W'(BITS - 1));

  assign start_now  = armed && tick && at_start_h && !busy;
  assign run_done   = busy && tick && last_phase && last_bit;
  assign sample_now = busy && tick && (phase == PH_W'(SAMPLE_AT));

  always_ff @(posedge clk) begin
    if (!rst_n)                                 armed <= 1'b0;
    else if (start_now)                         armed <= 1'b0;
    else if (vblank_start && enable && !busy)   armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
      bidx  <= '0;
    end else if (start_now) begin
      busy  <= 1'b1;
      phase <= '0;
      bidx  <= '0;
    end else if (busy && tick) begin
      if (last_phase) begin
        phase <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          bidx <= '0;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign auto_latch  = busy && (bidx == '0) &&
                       (phase >= PH_W'(LATCH_BEG)) && (phase < PH_W'(LATCH_END));
  assign auto_strobe = busy &&
                       (phase >= PH_W'(STROBE_BEG)) && (phase < PH_W'(STROBE_END));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run_done) |=> busy);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick && last_phase && last_bit));

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed && at_start_h && tick));

  // R13
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(phase) && $stable(bidx)));
endmodule

// File: rtl/pad_autopoll_lanes.sv
module pad_autopoll_lanes
  import pad_autopoll_pkg::*;
#(
  parameter int BITS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sample_now,
  input  logic                           run_done,
  input  logic [NUM_LANES-1:0]           line_in,
  output logic [NUM_LANES-1:0][BITS-1:0] res
);
  logic [NUM_LANES-1:0][BITS-1:0] shreg;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    // raw line is active low: a grounded line stores 1
    always_ff @(posedge clk) begin
      if (!rst_n)          shreg[k] <= '0;
      else if (sample_now) shreg[k] <= {shreg[k][BITS-2:0], ~line_in[k]};
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        res[k] <= '0;
      else if (run_done) res[k] <= shreg[k];
    end
  end

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_done |=> $stable(res));
endmodule

// File: rtl/pad_autopoll_portmux.sv
module pad_autopoll_portmux
  import pad_autopoll_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 start_now,
  input  logic                 run_done,
  input  logic                 auto_latch,
  input  logic                 auto_strobe,
  input  logic                 man_latch_wr,
  input  logic                 man_latch_val,
  input  logic [NUM_PORTS-1:0] man_rd,
  output logic                 pad_latch,
  output logic [NUM_PORTS-1:0] pad_clk
);
  logic                 man_latch_q;
  logic [NUM_PORTS-1:0] man_stb_q;

  // a run counts as a write of 1 then 0, so the latch ends low
  always_ff @(posedge clk) begin
    if (!rst_n)                       man_latch_q <= 1'b0;
    else if (start_now)               man_latch_q <= 1'b0;
    else if (man_latch_wr && !busy)   man_latch_q <= man_latch_val;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) man_stb_q[p] <= 1'b0;
      else        man_stb_q[p] <= man_rd[p] && !busy && !start_now;
    end
    assign pad_clk[p] = busy ? auto_strobe : man_stb_q[p];
  end

  assign pad_latch = busy ? auto_latch : man_latch_q;

  // R10
  man_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !man_latch_q);

  // R12
  post_run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> !pad_latch);

  // R5
  strobe_latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(pad_latch && (|pad_clk)));
endmodule

// File: rtl/pad_autopoll.sv
module pad_autopoll
  import pad_autopoll_pkg::*;
#(
  parameter int BITS       = 16,
  parameter int PERIOD     = 264,
  parameter int H_W        = 9,
  parameter int START_H    = 64,
  parameter int LATCH_BEG  = 4,
  parameter int LATCH_END  = 28,
  parameter int SAMPLE_AT  = 96,
  parameter int STROBE_BEG = 100,
  parameter int STROBE_END = 132
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            autoread_en,
  input  logic            vblank_start,
  input  logic [H_W-1:0]  hcount,
  input  logic            man_latch_wr,
  input  logic            man_latch_val,
  input  logic            man_rd1,
  input  logic            man_rd2,
  input  logic [1:0]      port1_d,
  input  logic [1:0]      port2_d,
  output logic            pad_latch,
  output logic            pad1_clk,
  output logic            pad2_clk,
  output logic [BITS-1:0] res1,
  output logic [BITS-1:0] res2,
  output logic [BITS-1:0] res3,
  output logic [BITS-1:0] res4,
  output logic            busy
);
  logic start_now, run_done, sample_now, auto_latch, auto_strobe;
  logic [NUM_PORTS-1:0][LINES_PER_PORT-1:0] pdat;
  logic [NUM_LANES-1:0]                     lane_in;
  logic [NUM_LANES-1:0][BITS-1:0]           lane_res;
  logic [NUM_PORTS-1:0]                     pclk;

  assign pdat[0] = port1_d;
  assign pdat[1] = port2_d;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_map
    assign lane_in[k] = pdat[lane_port(k)][lane_line(k)];
  end

  pad_autopoll_seq #(
    .BITS(BITS), .PERIOD(PERIOD), .H_W(H_W), .START_H(START_H),
    .LATCH_BEG(LATCH_BEG), .LATCH_END(LATCH_END), .SAMPLE_AT(SAMPLE_AT),
    .STROBE_BEG(STROBE_BEG), .STROBE_END(STROBE_END)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(autoread_en),
    .vblank_start(vblank_start), .hcount(hcount), .busy(busy),
    .start_now(start_now), .run_done(run_done), .sample_now(sample_now),
    .auto_latch(auto_latch), .auto_strobe(auto_strobe)
  );

  pad_autopoll_lanes #(.BITS(BITS)) u_lanes (
    .clk(clk), .rst_n(rst_n), .sample_now(sample_now), .run_done(run_done),
    .line_in(lane_in), .res(lane_res)
  );

  pad_autopoll_portmux u_mux (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_now(start_now),
    .run_done(run_done), .auto_latch(auto_latch), .auto_strobe(auto_strobe),
    .man_latch_wr(man_latch_wr), .man_latch_val(man_latch_val),
    .man_rd({man_rd2, man_rd1}), .pad_latch(pad_latch), .pad_clk(pclk)
  );

  assign pad1_clk = pclk[0];
  assign pad2_clk = pclk[1];
  assign res1 = lane_res[0];
  assign res2 = lane_res[1];
  assign res3 = lane_res[2];
  assign res4 = lane_res[3];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && (res1 == '0) && (res4 == '0)));
endmodule

// File: tb/pad_autopoll_tb.sv
module pad_autopoll_tb;
  localparam int START_H = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic tick_div = 1'b0;
  logic autoread_en = 1'b0;
  logic vblank_start = 1'b0;
  logic [8:0] hcount = '0;
  logic man_latch_wr = 1'b0, man_latch_val = 1'b0, man_rd1 = 1'b0, man_rd2 = 1'b0;
  logic [1:0] port1_d, port2_d;
  logic pad_latch, pad1_clk, pad2_clk, busy;
  logic [15:0] res1, res2, res3, res4;

  always #5 clk = ~clk;

  pad_autopoll u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .autoread_en(autoread_en),
    .vblank_start(vblank_start), .hcount(hcount), .man_latch_wr(man_latch_wr),
    .man_latch_val(man_latch_val), .man_rd1(man_rd1), .man_rd2(man_rd2),
    .port1_d(port1_d), .port2_d(port2_d), .pad_latch(pad_latch),
    .pad1_clk(pad1_clk), .pad2_clk(pad2_clk), .res1(res1), .res2(res2),
    .res3(res3), .res4(res4), .busy(busy)
  );

  always @(negedge clk) tick <= tick_div ? ~tick : 1'b1;

  // pad model: lane k on port k%2, line k/2; 16 buttons then 8 extra bits
  logic [15:0] btn [4];
  logic [7:0]  ext [4];
  logic [23:0] sh [4] = '{default: 24'h0};
  logic [1:0]  mprev = 2'b00;
  logic [1:0]  pclk;
  assign pclk = {pad2_clk, pad1_clk};

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (pad_latch)                         sh[k] <= {btn[k], ext[k]};
      else if (pclk[k % 2] && !mprev[k % 2]) sh[k] <= {sh[k][22:0], 1'b1};
    end
    mprev <= pclk;
  end
  assign port1_d = {~sh[2][23], ~sh[0][23]};
  assign port2_d = {~sh[3][23], ~sh[1][23]};

  // run monitor
  logic mon_clr = 1'b0;
  logic [63:0] snap = '0;
  int n_busy, n_latch, n_st1, n_st2, n_mism, n_chg, n_ovl;
  logic [1:0] mon_p = 2'b00;
  always @(negedge clk) begin
    mon_p <= pclk;
    if (mon_clr) begin
      n_busy <= 0; n_latch <= 0; n_st1 <= 0; n_st2 <= 0;
      n_mism <= 0; n_chg <= 0; n_ovl <= 0;
    end else if (busy) begin
      n_busy <= n_busy + 1;
      if (pad_latch) n_latch <= n_latch + 1;
      if (pad1_clk && !mon_p[0]) n_st1 <= n_st1 + 1;
      if (pad2_clk && !mon_p[1]) n_st2 <= n_st2 + 1;
      if (pad1_clk != pad2_clk) n_mism <= n_mism + 1;
      if (pad_latch && (pad1_clk || pad2_clk)) n_ovl <= n_ovl + 1;
      if ({res1, res2, res3, res4} != snap) n_chg <= n_chg + 1;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({res1, res2, res3, res4} == 64'h0, "R1", "results after reset", {res1, res2, res3, res4}, 0);
    chk({busy, pad_latch, pad1_clk, pad2_clk} == 4'b0, "R1", "controls after reset",
        {busy, pad_latch, pad1_clk, pad2_clk}, 0);
  endtask

  task automatic t_no_start();
    int seen;
    seen = 0;
    autoread_en = 1'b0;
    @(negedge clk); vblank_start = 1'b1;
    @(negedge clk); vblank_start = 1'b0; hcount = 9'(START_H);
    repeat (20) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R2", "no run with enable off", seen, 0);
    autoread_en = 1'b1;
    repeat (20) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R2", "no run without vblank pulse", seen, 0);
    hcount = '0;
  endtask

  // one full auto-poll run; slow = tick every other cycle; inject = manual requests mid-run
  task automatic t_run(input bit slow, input bit inject, input string tag);
    int waited, early;
    tick_div = slow;
    snap = {res1, res2, res3, res4};
    clear_mon();
    autoread_en = 1'b1;
    @(negedge clk); vblank_start = 1'b1;
    @(negedge clk); vblank_start = 1'b0; hcount = 9'(START_H - 1);
    early = 0;
    repeat (3) begin @(negedge clk); if (busy) early++; end
    chk(early == 0, "R2", {tag, " no start before position"}, early, 0);
    hcount = 9'(START_H);
    if (!slow) begin
      @(negedge clk);
      chk(busy == 1'b1, "R2", {tag, " busy one edge after position"}, busy, 1);
    end else begin
      repeat (2) @(negedge clk);
    end
    hcount = '0;
    if (inject) begin
      repeat (1000) @(negedge clk);
      man_latch_wr = 1'b1; man_latch_val = 1'b1; man_rd1 = 1'b1; man_rd2 = 1'b1;
      @(negedge clk);
      man_latch_wr = 1'b0; man_latch_val = 1'b0; man_rd1 = 1'b0; man_rd2 = 1'b0;
    end
    waited = 0;
    while (busy && waited < 20000) begin @(negedge clk); waited++; end
    #1;
    chk(n_busy == (slow ? 8448 : 4224), slow ? "R13" : "R3", {tag, " busy length"},
        n_busy, slow ? 8448 : 4224);
    chk(n_latch == (slow ? 48 : 24), "R4", {tag, " latch high cycles"}, n_latch, slow ? 48 : 24);
    chk(n_st1 == 16 && n_st2 == 16, inject ? "R10" : "R5", {tag, " strobe edges p1/p2"},
        {n_st1[15:0], n_st2[15:0]}, {16'd16, 16'd16});
    chk(n_mism == 0 && n_ovl == 0, "R5", {tag, " strobes aligned, off during latch"},
        n_mism + n_ovl, 0);
    chk(n_chg == 0, "R9", {tag, " results stable during run"}, n_chg, 0);
    // R6 R7 R8: lanes map in order, MSB first, inverted capture
    chk(res1 == btn[0], "R6", {tag, " res1 port1 line1"}, res1, btn[0]);
    chk(res2 == btn[1], "R7", {tag, " res2 port2 line1"}, res2, btn[1]);
    chk(res3 == btn[2], "R8", {tag, " res3 port1 line2"}, res3, btn[2]);
    chk(res4 == btn[3], "R6", {tag, " res4 port2 line2"}, res4, btn[3]);
    chk(pad_latch == 1'b0, inject ? "R10" : "R12", {tag, " latch low after run"}, pad_latch, 0);
    tick_div = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_after_run_manual();
    // after a run each line already shows extra bit 7
    @(negedge clk); #1;
    chk(port1_d[0] == ~ext[0][7], "R12", "p1 line1 shows 17th bit", port1_d[0], ~ext[0][7]);
    @(negedge clk); man_rd1 = 1'b1;
    @(negedge clk); man_rd1 = 1'b0;
    chk(pad1_clk == 1'b1 && pad2_clk == 1'b0, "R11", "manual strobe p1 only",
        {pad1_clk, pad2_clk}, 2'b10);
    @(negedge clk); #1;
    chk(pad1_clk == 1'b0, "R11", "manual strobe one cycle", pad1_clk, 0);
    chk(port1_d[0] == ~ext[0][6], "R12", "p1 line1 shifted to 18th bit", port1_d[0], ~ext[0][6]);
    chk(port2_d[0] == ~ext[1][7], "R11", "p2 not strobed", port2_d[0], ~ext[1][7]);
    man_latch_wr = 1'b1; man_latch_val = 1'b1;
    @(negedge clk); man_latch_wr = 1'b0;
    chk(pad_latch == 1'b1, "R11", "manual latch set", pad_latch, 1);
    man_latch_wr = 1'b1; man_latch_val = 1'b0;
    @(negedge clk); man_latch_wr = 1'b0;
    chk(pad_latch == 1'b0, "R11", "manual latch clear", pad_latch, 0);
  endtask

  task automatic main();
    t_reset();
    t_no_start();
    btn = '{16'hA5C3, 16'h1F08, 16'h8001, 16'h7E42};
    ext = '{8'h96, 8'h3C, 8'h5A, 8'hC1};
    t_run(1'b0, 1'b0, "run_a");
    t_after_run_manual();
    btn = '{16'hFFFF, 16'h0000, 16'h4000, 16'h0002};
    t_run(1'b0, 1'b1, "run_inject");
    btn = '{16'h3CA5, 16'hE817, 16'h0F0F, 16'hB6D9};
    t_run(1'b1, 1'b0, "run_slow");
  endtask

  initial begin
    fork
      main();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule